// File: doc/BRIEF.md
# Low-Power Mode Entry Controller

This block chooses the low-power state the chip enters when the processor executes a sleep instruction, and drives the clock enables that go with each state. A one-cycle request strobe is qualified by a standby-select bit, an enable bit for the all-clock-stop feature and the current module-stop register value. Together these pick one of three states: ordinary sleep, all-module-clocks-stopped, or software standby.

The two deeper states shut off the bus controller and I/O port clocks. Another master may own the external bus, and it must be able to hand the bus back. So a request for either deep state made while the bus-released flag is high is parked in a pending register. It takes effect on the first clock edge at which the flag is seen low. No second request is needed.

A wake-up interrupt returns sleep and all-clock-stop to active on the next edge. Standby first runs a fixed oscillator-settling count, with every clock still gated, before it returns to active.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: After reset the state is active (2'b00), every clock enable is 1 and the bus-release enable is 1.
- R2: A request with standby-select 0 enters all-clock-stop (2'b10) on the next edge when the feature enable is 1 and the module-stop value is 16'hFFFF or 16'hFFFE. Any other combination enters sleep (2'b01).
- R3: In sleep the CPU clock enable is 0. The bus controller, I/O, peripheral and timer enables and the bus-release enable stay 1.
- R4: In all-clock-stop the CPU, bus controller, I/O and peripheral enables and the bus-release enable are 0. The timer enable is 1 only if the module-stop value latched with the request was 16'hFFFE.
- R5: A request with standby-select 1 enters standby (2'b11), whatever the other inputs are. There, every clock enable and the bus-release enable are 0.
- R6: A standby or all-clock-stop request made while bus-released is 1 leaves the state active. The state enters the requested target on the first edge at which bus-released is 0. A plain sleep request is never deferred.
- R7: In sleep or all-clock-stop, a wake-up input sampled at an edge returns the state to active at that edge.
- R8: In standby, a wake-up sampled at edge k starts the settling count. The state stays 2'b11 with all clocks gated until edge k+SETTLE_CYCLES, where it becomes active.
- R9: A sleep request is ignored outside the active state and while a deferred request is pending.
- R10: A wake-up while a request is pending cancels it, and the state stays active after the bus is recovered.
- R11: The target and timer choice of a deferred request are fixed when the request is made. Later changes of the select, enable or module-stop inputs do not alter them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sleep_req | input | 1 | One-cycle sleep instruction strobe |
| stby_sel | input | 1 | 1 selects software standby |
| acs_en | input | 1 | Enables all-clock-stop selection |
| mstp_val | input | MSTP_W | Module-stop register value |
| bus_released | input | 1 | External bus currently handed to another master |
| wake_irq | input | 1 | Wake-up interrupt |
| pstate | output | 2 | Power state: 00 active, 01 sleep, 10 all-clock-stop, 11 standby |
| cpu_clk_en | output | 1 | CPU clock enable |
| bsc_clk_en | output | 1 | Bus controller clock enable |
| io_clk_en | output | 1 | I/O port clock enable |
| periph_clk_en | output | 1 | Peripheral clock enable |
| tmr_clk_en | output | 1 | 8-bit timer clock enable |
| rel_fn_en | output | 1 | External bus release function enabled |

## Verification
The hardest situation to reach is a deep-state request that is parked while the bus is away. Inside that window the bench changes the select, enable and module-stop inputs, pulses further requests, and sometimes fires a wake-up, all before the bus comes back. The bench sweeps every combination of feature enable, standby select and bus-released level over a set of module-stop values. That set covers all-ones, each single cleared bit and all-zeros. Each case is driven through the deferral path whenever the target is deep, and the bench checks the exact edge at which the state moves.

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl #(
  parameter int MSTP_W = 16,
  parameter int SETTLE_CYCLES = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sleep_req,
  input  logic              stby_sel,
  input  logic              acs_en,
  input  logic [MSTP_W-1:0] mstp_val,
  input  logic              bus_released,
  input  logic              wake_irq,
  output logic [1:0]        pstate,
  output logic              cpu_clk_en,
  output logic              bsc_clk_en,
  output logic              io_clk_en,
  output logic              periph_clk_en,
  output logic              tmr_clk_en,
  output logic              rel_fn_en
);
  localparam int CW = (SETTLE_CYCLES > 1) ? $clog2(SETTLE_CYCLES) : 1;
  localparam logic [MSTP_W-1:0] ALL_OFF = '1;
  localparam logic [MSTP_W-1:0] TMR_ONLY = {{(MSTP_W-1){1'b1}}, 1'b0};

  typedef enum logic [1:0] {ACT = 2'b00, SLP = 2'b01, ACS = 2'b10, STBY = 2'b11} pst_t;

  pst_t          st;
  logic          pend, pend_stby, keep_tmr, settling;
  logic [CW-1:0] cnt;

  wire  is_tmr = (mstp_val == TMR_ONLY);
  wire  deep_ok = acs_en && (mstp_val == ALL_OFF || is_tmr);
  pst_t tgt;
  assign tgt = stby_sel ? STBY : (deep_ok ? ACS : SLP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= ACT;
      pend      <= 1'b0;
      pend_stby <= 1'b0;
      keep_tmr  <= 1'b0;
      settling  <= 1'b0;
      cnt       <= '0;
    end else begin
      case (st)
        ACT: begin
          if (pend) begin
            if (wake_irq) pend <= 1'b0;
            else if (!bus_released) begin
              st   <= pend_stby ? STBY : ACS;
              pend <= 1'b0;
            end
          end else if (sleep_req) begin
            keep_tmr <= is_tmr && !stby_sel;
            if (tgt != SLP && bus_released) begin
              pend      <= 1'b1;
              pend_stby <= stby_sel;
            end else begin
              st <= tgt;
            end
          end
        end
        SLP, ACS: if (wake_irq) st <= ACT;
        STBY: begin
          if (!settling) begin
            if (wake_irq) begin
              settling <= 1'b1;
              cnt      <= '0;
            end
          end else if (cnt == CW'(SETTLE_CYCLES - 1)) begin
            st       <= ACT;
            settling <= 1'b0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: st <= ACT;
      endcase
    end
  end

  wire lite = (st == ACT) || (st == SLP);
  assign pstate        = st;
  assign cpu_clk_en    = (st == ACT);
  assign bsc_clk_en    = lite;
  assign io_clk_en     = lite;
  assign periph_clk_en = lite;
  assign tmr_clk_en    = lite || (st == ACS && keep_tmr);
  assign rel_fn_en     = lite;

  // R6
  defer_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pend && bus_released) |=> st == ACT);
  // R6
  defer_fire_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ACT && pend && !bus_released && !wake_irq) |=> st[1]);
  // R6
  no_deep_entry_while_released_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(st) == ACT && st[1]) |-> !$past(bus_released));
  // R7
  light_wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((st == SLP || st == ACS) && wake_irq) |=> st == ACT);
  // R8
  stby_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == STBY && !settling) |=> st == STBY);
  // R9
  light_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((st == SLP || st == ACS) && !wake_irq) |=> $stable(st));
endmodule

// File: tb/sim_pwr_mode_ctrl.sv
module sim_pwr_mode_ctrl;
  localparam int S = 16;
  logic clk = 0, rst_n = 0;
  logic sleep_req = 0, stby_sel = 0, acs_en = 0, bus_released = 0, wake_irq = 0;
  logic [15:0] mstp_val = '0;
  logic [1:0] pstate;
  logic cpu_clk_en, bsc_clk_en, io_clk_en, periph_clk_en, tmr_clk_en, rel_fn_en;
  int checks = 0, fails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  pwr_mode_ctrl #(.MSTP_W(16), .SETTLE_CYCLES(S)) u0 (
    .clk(clk), .rst_n(rst_n), .sleep_req(sleep_req), .stby_sel(stby_sel), .acs_en(acs_en),
    .mstp_val(mstp_val), .bus_released(bus_released), .wake_irq(wake_irq), .pstate(pstate),
    .cpu_clk_en(cpu_clk_en), .bsc_clk_en(bsc_clk_en), .io_clk_en(io_clk_en),
    .periph_clk_en(periph_clk_en), .tmr_clk_en(tmr_clk_en), .rel_fn_en(rel_fn_en));

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  function automatic logic [5:0] enables(input logic [1:0] s, input logic tmr);
    logic lite = (s == 2'b00) || (s == 2'b01);
    return {s == 2'b00, lite, lite, lite, lite || (s == 2'b10 && tmr), lite};
  endfunction

  task automatic chk_en(input string req, input logic [1:0] s, input logic tmr);
    chk(req, {cpu_clk_en, bsc_clk_en, io_clk_en, periph_clk_en, tmr_clk_en, rel_fn_en},
        enables(s, tmr));
  endtask

  task automatic run_case(input logic a, input logic [15:0] m, input logic sb, input logic br);
    logic [1:0] tgt;
    logic tmr;
    tgt = sb ? 2'b11 : ((a && (m == 16'hFFFF || m == 16'hFFFE)) ? 2'b10 : 2'b01);
    tmr = !sb && m == 16'hFFFE;
    acs_en = a; mstp_val = m; stby_sel = sb; bus_released = br; sleep_req = 1;
    tick();
    sleep_req = 0;
    if (br && tgt != 2'b01) begin
      chk("R6 deferred stays active", pstate, 2'b00);
      acs_en = ~a; mstp_val = ~m; stby_sel = ~sb;
      tick(2);
      chk("R6 still active while released", pstate, 2'b00);
      sleep_req = 1; tick(); sleep_req = 0;
      chk("R9 request ignored while pending", pstate, 2'b00);
      bus_released = 0;
      tick();
      chk("R11 latched target after recovery", pstate, tgt);
    end else begin
      chk("R2 R5 R6 target", pstate, tgt);
    end
    chk_en(tgt == 2'b01 ? "R3 sleep enables" : (tgt == 2'b10 ? "R4 acs enables" : "R5 stby enables"),
           tgt, tmr);
    stby_sel = ~stby_sel; acs_en = ~acs_en; sleep_req = 1; tick(); sleep_req = 0;
    chk("R9 request ignored in low power", pstate, tgt);
    bus_released = 0;
    wake_irq = 1; tick(); wake_irq = 0;
    if (tgt != 2'b11) begin
      chk("R7 wake to active", pstate, 2'b00);
    end else begin
      tick(S - 1);
      chk("R8 still standby while settling", pstate, 2'b11);
      chk_en("R8 clocks gated while settling", 2'b11, 1'b0);
      tick();
      chk("R8 active after settle", pstate, 2'b00);
    end
    chk_en("R1 active enables", 2'b00, 1'b0);
  endtask

  initial begin
    #3000000;
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    tick(2);
    rst_n = 1;
    tick();
    chk("R1 reset state", pstate, 2'b00);
    chk_en("R1 reset enables", 2'b00, 1'b0);

    for (int i = 0; i < 18; i++) begin
      logic [15:0] m;
      m = (i < 16) ? ~(16'h1 << i) : (i == 16 ? 16'hFFFF : 16'h0000);
      for (int c = 0; c < 8; c++) run_case(c[0], m, c[1], c[2]);
    end

    acs_en = 1; mstp_val = 16'hFFFF; stby_sel = 0; bus_released = 1; sleep_req = 1;
    tick(); sleep_req = 0;
    wake_irq = 1; tick(); wake_irq = 0;
    bus_released = 0; tick(2);
    chk("R10 wake cancels pending", pstate, 2'b00);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule